// File: doc/BRIEF.md
# Direct-Mapped Instruction Cache

This block sits between a processor fetch port and external memory and keeps a copy of recently fetched program longwords. It has 64 entries, one aligned 32-bit longword each (256 bytes in total). Address bits 7:2 select the entry. The tag stored with each entry is address bits 31:8 plus bit 2 of the 3-bit address-space code. Because that bit is part of the tag, the user and supervisor copies of one address occupy the same entry but never match each other.

Every processor access is latched and then looked up. A program-space read that finds a valid entry with a matching tag is answered from the cache in the cycle after the request, and no memory cycle takes place. A program-space read that misses goes to memory through a request/ready handshake. The returned longword is then handed to the processor and written into the indexed entry. Data-space reads and all writes go to memory as they are and leave the cache untouched. A one-cycle invalidate input clears every valid bit.

The controller has four states:
- `ST_IDLE` waits for a request and latches it (IDLE→LOOKUP on `cpu_req`).
- `ST_LOOKUP` compares the tag. On a hit it answers and moves LOOKUP→IDLE. Otherwise it moves LOOKUP→MEM.
- `ST_MEM` drives the memory request until `mem_ready`, then moves MEM→RESP. The refill happens on that same edge.
- `ST_RESP` answers with the captured memory data and moves RESP→IDLE.

Top module: `icache_top`

## Requirements
- R1: After reset `cpu_ready` and `mem_req` are low, all entries are invalid, and the first program read of any address goes to memory.
- R2: The entry index is address bits 7:2 (64 entries). Two program reads whose addresses differ only by a multiple of 256 share an entry, and the second evicts the first.
- R3: Address bits 31:8 are kept as tag. An access to the same index with different upper bits misses.
- R4: Address-space code bit 2 is part of the tag. Code 3'b010 (user program) and 3'b110 (supervisor program) at the same address are separate lines that evict each other.
- R5: Only reads with code bits 1:0 equal to 2'b10 can hit or allocate. Any other code is sent to memory on every access and neither hits nor changes an entry.
- R6: A read that hits a valid entry with a matching tag raises `cpu_ready` exactly one cycle after the request edge, returns the stored longword, and raises no `mem_req`.
- R7: A cacheable miss holds `mem_req` with stable address until `mem_ready`. In the next cycle it returns the memory data with `cpu_ready` high and fills the entry with the new tag.
- R8: A one-cycle `inv_all` pulse clears every valid bit, so the next program read of any address misses.
- R9: Address bits 1:0 do not take part in lookup. The whole longword is returned.
- R10: Writes are passed to memory with unchanged address, data and code. They never allocate and never change a cached entry.
- R11: Each accepted request produces exactly one single-cycle `cpu_ready` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inv_all | input | 1 | Clear all valid bits |
| cpu_req | input | 1 | Request pulse, accepted when idle |
| cpu_we | input | 1 | Request is a write |
| cpu_fc | input | 3 | Address-space code |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid with cpu_ready |
| cpu_ready | output | 1 | Access complete |
| mem_req | output | 1 | Memory request, held until mem_ready |
| mem_we | output | 1 | Memory write |
| mem_fc | output | 3 | Address-space code to memory |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| mem_ready | input | 1 | Memory access done |

## Verification
Directed sequences cover the following cases:
- a repeated read, which shows a hit against a miss;
- an address plus 256, which isolates the index;
- a changed upper field, which checks tag width;
- a user/supervisor pair, which checks the space bit;
- a data-space read of a cached address, which shows the bypass;
- varied low address bits, which show they are ignored;
- a write to a cached address, which shows writes are not allocated.

Random traffic then draws addresses from a few upper fields with random index and offset, mixes all eight space codes, writes, invalidates and memory latencies, and changes the memory contents between accesses. A stale hit is therefore told apart from a refetch by its data as well as by the count of memory transactions.

// File: rtl/icache_pkg.sv
package icache_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_MEM,
        ST_RESP
    } ctl_state_e;

    localparam logic [1:0] SPACE_PROG = 2'b10;

    function automatic logic space_is_prog(input logic [2:0] fc);
        return fc[1:0] == SPACE_PROG;
    endfunction

endpackage

// File: rtl/icache_tags.sv
module icache_tags #(
    parameter int IDX_W = 6,
    parameter int TAG_W = 25
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    inv_all,
    input  logic [IDX_W-1:0]        rd_idx,
    input  logic [TAG_W-1:0]        rd_tag,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [TAG_W-1:0]        wr_tag,
    output logic                    hit,
    output logic [(1<<IDX_W)-1:0]   valid_vec
);

    localparam int ENTRIES = 1 << IDX_W;

    logic [TAG_W-1:0] tag_mem [ENTRIES];

    // One valid flop per entry; invalidate takes priority over refill.
    for (genvar e = 0; e < ENTRIES; e++) begin : g_valid
        always_ff @(posedge clk) begin
            if (!rst_n || inv_all) begin
                valid_vec[e] <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(e))) begin
                valid_vec[e] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_idx] <= wr_tag;
        end
    end

    always_comb begin
        hit = valid_vec[rd_idx] && (tag_mem[rd_idx] == rd_tag);
    end

endmodule

// File: rtl/icache_data.sv
module icache_data #(
    parameter int IDX_W  = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data
);

    localparam int ENTRIES = 1 << IDX_W;

    logic [DATA_W-1:0] line_mem [ENTRIES];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            line_mem[wr_idx] <= wr_data;
        end
    end

    always_comb begin
        rd_data = line_mem[rd_idx];
    end

endmodule

// File: rtl/icache_ctrl.sv
module icache_ctrl
    import icache_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cpu_req,
    input  logic       cacheable,
    input  logic       tag_hit,
    input  logic       mem_ready,
    output ctl_state_e state,
    output logic       load_req,
    output logic       fill_en,
    output logic       resp_load,
    output logic       mem_req,
    output logic       cpu_ready,
    output logic       sel_cache
);

    ctl_state_e state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (cpu_req) state_nx = ST_LOOKUP;
            ST_LOOKUP: state_nx = (cacheable && tag_hit) ? ST_IDLE : ST_MEM;
            ST_MEM:    if (mem_ready) state_nx = ST_RESP;
            ST_RESP:   state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        load_req  = 1'b0;
        fill_en   = 1'b0;
        resp_load = 1'b0;
        mem_req   = 1'b0;
        cpu_ready = 1'b0;
        sel_cache = 1'b0;
        unique case (state)
            ST_IDLE: begin
                load_req = cpu_req;
            end
            ST_LOOKUP: begin
                cpu_ready = cacheable && tag_hit;
                sel_cache = 1'b1;
            end
            ST_MEM: begin
                mem_req   = 1'b1;
                resp_load = mem_ready;
                fill_en   = mem_ready && cacheable;
            end
            ST_RESP: begin
                cpu_ready = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/icache_top.sv
module icache_top
    import icache_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 6,
    parameter int OFF_W  = 2,
    parameter int FC_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inv_all,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [FC_W-1:0]   cpu_fc,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [FC_W-1:0]   mem_fc,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready
);

    localparam int UPPER_LO = OFF_W + IDX_W;
    localparam int UPPER_W  = ADDR_W - UPPER_LO;
    localparam int TAG_W    = UPPER_W + 1;
    localparam int ENTRIES  = 1 << IDX_W;

    ctl_state_e          state;
    logic                load_req, fill_en, resp_load, sel_cache;
    logic                tag_hit, cacheable;
    logic [ENTRIES-1:0]  valid_vec;

    logic [ADDR_W-1:0]   lat_addr;
    logic [FC_W-1:0]     lat_fc;
    logic                lat_we;
    logic [DATA_W-1:0]   lat_wdata;
    logic [DATA_W-1:0]   resp_q;
    logic [DATA_W-1:0]   line_rd;

    logic [IDX_W-1:0]    cur_idx;
    logic [TAG_W-1:0]    cur_tag;

    // Request latch: captured once per accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_addr  <= '0;
            lat_fc    <= '0;
            lat_we    <= 1'b0;
            lat_wdata <= '0;
        end else if (load_req) begin
            lat_addr  <= cpu_addr;
            lat_fc    <= cpu_fc;
            lat_we    <= cpu_we;
            lat_wdata <= cpu_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_q <= '0;
        end else if (resp_load) begin
            resp_q <= mem_rdata;
        end
    end

    always_comb begin
        cur_idx   = lat_addr[OFF_W +: IDX_W];
        cur_tag   = {lat_fc[FC_W-1], lat_addr[ADDR_W-1:UPPER_LO]};
        cacheable = space_is_prog(lat_fc) && !lat_we;
    end

    icache_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_req   (cpu_req),
        .cacheable (cacheable),
        .tag_hit   (tag_hit),
        .mem_ready (mem_ready),
        .state     (state),
        .load_req  (load_req),
        .fill_en   (fill_en),
        .resp_load (resp_load),
        .mem_req   (mem_req),
        .cpu_ready (cpu_ready),
        .sel_cache (sel_cache)
    );

    icache_tags #(
        .IDX_W (IDX_W),
        .TAG_W (TAG_W)
    ) u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .inv_all   (inv_all),
        .rd_idx    (cur_idx),
        .rd_tag    (cur_tag),
        .wr_en     (fill_en),
        .wr_idx    (cur_idx),
        .wr_tag    (cur_tag),
        .hit       (tag_hit),
        .valid_vec (valid_vec)
    );

    icache_data #(
        .IDX_W  (IDX_W),
        .DATA_W (DATA_W)
    ) u_data (
        .clk     (clk),
        .rd_idx  (cur_idx),
        .rd_data (line_rd),
        .wr_en   (fill_en),
        .wr_idx  (cur_idx),
        .wr_data (mem_rdata)
    );

    always_comb begin
        cpu_rdata = sel_cache ? line_rd : resp_q;
        mem_we    = lat_we;
        mem_fc    = lat_fc;
        mem_addr  = lat_addr;
        mem_wdata = lat_wdata;
    end

endmodule

// File: rtl/icache_chk.sv
module icache_chk #(
    parameter int ENTRIES = 64,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               inv_all,
    input logic               cpu_ready,
    input logic [DATA_W-1:0]  cpu_rdata,
    input logic               mem_req,
    input logic               mem_we,
    input logic               mem_ready,
    input logic [ADDR_W-1:0]  mem_addr,
    input logic [DATA_W-1:0]  mem_rdata,
    input logic               tag_hit,
    input logic               fill_en,
    input logic               sel_cache,
    input logic [ENTRIES-1:0] valid_vec
);

    // R11
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

    // R7
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

    // R7
    mem_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready) |=> (cpu_ready && !mem_req));

    // R7
    resp_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready) |=> (cpu_rdata == $past(mem_rdata)));

    // R6
    hit_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && sel_cache) |-> (tag_hit && !mem_req));

    // R8
    inv_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> (valid_vec == '0));

    // R10
    write_no_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |-> !mem_we);

endmodule

bind icache_top icache_chk #(
    .ENTRIES (1 << IDX_W),
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .inv_all   (inv_all),
    .cpu_ready (cpu_ready),
    .cpu_rdata (cpu_rdata),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata),
    .tag_hit   (tag_hit),
    .fill_en   (fill_en),
    .sel_cache (sel_cache),
    .valid_vec (valid_vec)
);

// File: tb/icache_top_tb_top.sv
module icache_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        inv_all = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [2:0]  cpu_fc = 3'b000;
    logic [31:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_ready;
    logic        mem_req, mem_we;
    logic [2:0]  mem_fc;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;

    always #4 clk = ~clk;

    icache_top dut_i (
        .clk(clk), .rst_n(rst_n), .inv_all(inv_all),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_fc(cpu_fc),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_fc(mem_fc),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    int n_chk = 0;
    int n_err = 0;
    int txn = 0;
    int unsigned epoch = 0;
    bit done = 0;

    logic [31:0] seen_addr, seen_wdata;
    logic [2:0]  seen_fc;
    logic        seen_we;

    // Reference model of the cache, built from the requirements.
    bit          mv [64];
    logic [24:0] mt [64];
    logic [31:0] md [64];

    function automatic logic [31:0] memf(input logic [31:0] a, input logic [2:0] fc,
                                         input int unsigned ep);
        return {a[31:2], 2'b00} ^ {fc, 29'h0} ^ (ep * 32'h9E37_79B9);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Memory responder with a random latency.
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req && !mem_ready) begin
                txn++;
                seen_addr  = mem_addr;
                seen_wdata = mem_wdata;
                seen_fc    = mem_fc;
                seen_we    = mem_we;
                repeat ($urandom_range(0, 3)) @(negedge clk);
                mem_rdata = memf(mem_addr, mem_fc, epoch);
                mem_ready = 1'b1;
                @(negedge clk);
                mem_ready = 1'b0;
            end
        end
    end

    task automatic do_inv();
        inv_all = 1'b1;
        @(negedge clk);
        inv_all = 1'b0;
        for (int i = 0; i < 64; i++) mv[i] = 0;
        @(negedge clk);
    endtask

    // One access; returns whether it was served without a memory transaction.
    task automatic access(input logic we, input logic [2:0] fc, input logic [31:0] a,
                          input logic [31:0] wd, output bit hit_obs,
                          output logic [31:0] rd);
        bit          cacheable;
        bit          pred_hit;
        int          idx;
        int          t0;
        int          lat;
        logic [24:0] tg;
        logic [31:0] exp_d;
        string       tag;
        idx       = int'(a[7:2]);
        tg        = {fc[2], a[31:8]};
        cacheable = (fc[1:0] == 2'b10) && !we;
        pred_hit  = cacheable && mv[idx] && (mt[idx] == tg);
        exp_d     = pred_hit ? md[idx] : memf(a, fc, epoch);
        tag       = cacheable ? (pred_hit ? "R6" : "R7") : (we ? "R10" : "R5");
        t0        = txn;
        cpu_req = 1'b1; cpu_we = we; cpu_fc = fc; cpu_addr = a; cpu_wdata = wd;
        @(negedge clk);
        cpu_req = 1'b0;
        lat = 1;
        while (!cpu_ready && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        rd = cpu_rdata;
        hit_obs = (txn == t0);
        chk(cpu_ready === 1'b1, tag, 32'(cpu_ready), 32'd1);
        chk(hit_obs == pred_hit, tag, 32'(txn - t0), pred_hit ? 32'd0 : 32'd1);
        if (pred_hit) chk(lat == 1, "R6", 32'(lat), 32'd1);
        if (!we) chk(rd === exp_d, tag, rd, exp_d);
        if (!hit_obs) begin
            chk(seen_addr === a && seen_fc === fc && seen_we === we,
                we ? "R10" : tag, seen_addr, a);
            if (we) chk(seen_wdata === wd, "R10", seen_wdata, wd);
        end
        if (cacheable && !pred_hit) begin
            mv[idx] = 1; mt[idx] = tg; md[idx] = exp_d;
        end
        @(negedge clk);
        chk(cpu_ready === 1'b0, "R11", 32'(cpu_ready), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_err++; n_chk++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        bit          h;
        logic [31:0] d, d2;
        logic [31:0] A;
        void'($urandom(32'd1234));
        for (int i = 0; i < 64; i++) mv[i] = 0;
        repeat (4) @(negedge clk);
        chk(cpu_ready === 1'b0 && mem_req === 1'b0, "R1", {cpu_ready, mem_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cpu_ready === 1'b0 && mem_req === 1'b0, "R1", {cpu_ready, mem_req}, 0);

        A = 32'h0012_3440;
        access(0, 3'b010, A, 0, h, d);
        chk(h == 0, "R1", 32'(h), 0);
        access(0, 3'b010, A, 0, h, d);
        chk(h == 1, "R6", 32'(h), 1);
        // R9: low address bits ignored
        access(0, 3'b010, A + 32'd3, 0, h, d2);
        chk(h == 1 && d2 == d, "R9", d2, d);
        // R2: +256 shares index and evicts
        access(0, 3'b010, A + 32'd256, 0, h, d);
        chk(h == 0, "R2", 32'(h), 0);
        access(0, 3'b010, A, 0, h, d);
        chk(h == 0, "R2", 32'(h), 0);
        // R3: upper tag bit
        access(0, 3'b010, A ^ 32'h8000_0000, 0, h, d);
        chk(h == 0, "R3", 32'(h), 0);
        // R4: supervisor vs user
        access(0, 3'b010, A, 0, h, d);
        access(0, 3'b110, A, 0, h, d2);
        chk(h == 0 && d2 != d, "R4", d2, d);
        access(0, 3'b010, A, 0, h, d);
        chk(h == 0, "R4", 32'(h), 0);
        // R5: data-space read goes out and does not touch the entry
        epoch++;
        access(0, 3'b001, A, 0, h, d2);
        chk(h == 0, "R5", 32'(h), 0);
        access(0, 3'b010, A, 0, h, d2);
        chk(h == 1 && d2 == d, "R5", d2, d);
        // R10: write to a cached address
        access(1, 3'b010, A, 32'hCAFE_F00D, h, d2);
        chk(h == 0, "R10", 32'(h), 0);
        access(0, 3'b010, A, 0, h, d2);
        chk(h == 1 && d2 == d, "R10", d2, d);
        // R8: invalidate
        do_inv();
        access(0, 3'b010, A, 0, h, d2);
        chk(h == 0, "R8", 32'(h), 0);

        for (int n = 0; n < 600; n++) begin
            logic [31:0] ra;
            logic [2:0]  rf;
            logic        rw;
            ra = {$urandom_range(0, 3) == 0 ? 24'h00_0000 : 24'(32'h10 * $urandom_range(0, 3)),
                  6'($urandom), 2'($urandom)};
            rf = ($urandom_range(0, 3) != 0) ? {1'($urandom), 2'b10} : 3'($urandom);
            rw = ($urandom_range(0, 7) == 0);
            if ($urandom_range(0, 15) == 0) epoch++;
            if ($urandom_range(0, 63) == 0) do_inv();
            access(rw, rf, ra, $urandom, h, d);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule